// File: doc/BRIEF.md
# External Bus Wait-State Stretcher

This block lengthens external memory cycles on behalf of a processor core. Each access arrives with a small selector naming one of five external address ranges. A control word holds one wait count per range and one global doubling bit. When an access is accepted, the block holds a stall line high for the programmed number of machine cycles. It then samples an external ready line and keeps the stall high for as long as that line is low. Completion is signalled by a one-cycle done pulse.

The wait count W of an access is the 3-bit field of its range, multiplied by one or by two. With the doubling bit set, the largest software extension is 14 cycles. A peripheral that needs more time holds ready low. The control word is copied into the access when the access is accepted, so a write during an access takes effect only from the next access. The block also drives a clock-enable for its counting logic. That enable is low whenever every range is programmed to zero and no counted wait is in progress. This lets the counter's clock be gated off in the power-saving case.

Top module: `xbus_wait_gen`

## Requirements
- R1: After reset, stall and done are low, every range has a wait count of 7, the doubling bit is clear, and count_clk_en is high.
- R2: The control word is 16 bits. Range r uses bits [3r+2:3r] for r = 0..4, and bit 15 is the doubling bit. A write with cfg_we high replaces the whole word at that clock edge.
- R3: A request is accepted when req is high in an idle cycle, meaning stall and done are both low. Stall rises in the next cycle. With ready high, stall stays high for exactly W+1 cycles. Done follows for exactly one cycle, and stall is low while done is high.
- R4: When the doubling bit is set, W is twice the range field. A field of 7 then gives 14 wait cycles, which is 15 stall cycles.
- R5: ext_ready is ignored while the W counted cycles run. After they run out, stall continues while ext_ready is low. Done comes in the cycle after ext_ready is sampled high. If ext_ready is first seen high at the end of cycle k after acceptance, the stall length is max(W,k-1)+1.
- R6: A request present during the done cycle is not accepted. If it is still present in the following idle cycle, it is accepted then.
- R7: A control write during an access does not change that access. A write in the same cycle as an acceptance leaves that access with the value held before the write.
- R8: count_clk_en is low when all five range fields are zero, whatever the doubling bit, and no counted wait is running. An access with W = 0 stalls for exactly one cycle.
- R9: Each range uses only its own field. Programming different counts per range gives different stall lengths per selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write value |
| req | input | 1 | External access request |
| req_range | input | 3 | Range selector of the access (0..4) |
| ext_ready | input | 1 | External ready; low holds the cycle open |
| stall | output | 1 | Stall to the processor side |
| done | output | 1 | One-cycle completion pulse |
| count_clk_en | output | 1 | Clock enable of the counting logic |

## Verification
Two functions can land on the same clock edge: a control word write and the acceptance of an access. The bench drives cfg_we and req in the same idle cycle, with new contents that would change the wait count of the selected range. It then judges the access by its stall length, which must match the old count. A second case overlaps a write with a running wait. There the old count must also hold, and the new one must appear only on the following access.

// File: rtl/xbus_wait_pkg.sv
package xbus_wait_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_RDY  = 2'd2,
    ST_DONE = 2'd3
  } wait_state_t;

endpackage

// File: rtl/xbus_rst_sync.sv
module xbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/xbus_wait_cfg.sv
module xbus_wait_cfg #(
  parameter int N_RANGES = 5,
  parameter int FIELD_W  = 3,
  localparam int CFG_W   = N_RANGES * FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg,
  output logic             fields_zero
);

  localparam logic [CFG_W-1:0] RST_VAL = {1'b0, {N_RANGES{ {FIELD_W{1'b1}} }}};

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) begin
      cfg_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= RST_VAL;
    end else begin
      cfg_q <= cfg_d;
    end
  end

  assign cfg         = cfg_q;
  assign fields_zero = ~|cfg_q[N_RANGES*FIELD_W-1:0];

endmodule

// File: rtl/xbus_wait_calc.sv
module xbus_wait_calc #(
  parameter int N_RANGES = 5,
  parameter int FIELD_W  = 3,
  localparam int CFG_W   = N_RANGES * FIELD_W + 1,
  localparam int SEL_W   = $clog2(N_RANGES),
  localparam int CNT_W   = FIELD_W + 1
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] wait_cnt
);

  logic [FIELD_W-1:0] fields [N_RANGES];
  logic [FIELD_W-1:0] field_sel;
  logic               dbl;

  for (genvar g = 0; g < N_RANGES; g++) begin : g_field
    assign fields[g] = cfg[g*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field_sel = '0;
    for (int i = 0; i < N_RANGES; i++) begin
      if (sel == SEL_W'(i)) begin
        field_sel = fields[i];
      end
    end
  end

  assign dbl      = cfg[CFG_W-1];
  assign wait_cnt = dbl ? {field_sel, 1'b0} : {1'b0, field_sel};

endmodule

// File: rtl/xbus_wait_seq.sv
module xbus_wait_seq
  import xbus_wait_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [CNT_W-1:0] wait_cnt,
  input  logic             ext_ready,
  output logic             stall,
  output logic             done,
  output logic             wait_phase,
  output logic             rdy_phase
);

  wait_state_t      st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_ce;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    cnt_ce = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req) begin
          if (wait_cnt == '0) begin
            st_d = ST_RDY;
          end else begin
            st_d   = ST_WAIT;
            cnt_d  = wait_cnt;
            cnt_ce = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        cnt_d  = cnt_q - CNT_W'(1);
        cnt_ce = 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          st_d = ST_RDY;
        end
      end
      ST_RDY: begin
        if (ext_ready) begin
          st_d = ST_DONE;
        end
      end
      ST_DONE: begin
        st_d = ST_IDLE;
      end
      default: begin
        st_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_ce) begin
      cnt_q <= cnt_d;
    end
  end

  assign wait_phase = (st_q == ST_WAIT);
  assign rdy_phase  = (st_q == ST_RDY);
  assign stall      = wait_phase | rdy_phase;
  assign done       = (st_q == ST_DONE);

endmodule

// File: rtl/xbus_wait_gen.sv
module xbus_wait_gen #(
  parameter int N_RANGES = 5,
  parameter int FIELD_W  = 3,
  localparam int CFG_W   = N_RANGES * FIELD_W + 1,
  localparam int SEL_W   = $clog2(N_RANGES),
  localparam int CNT_W   = FIELD_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             req,
  input  logic [SEL_W-1:0] req_range,
  input  logic             ext_ready,
  output logic             stall,
  output logic             done,
  output logic             count_clk_en
);

  logic             rst_n_sync;
  logic [CFG_W-1:0] cfg;
  logic             fields_zero;
  logic [CNT_W-1:0] wait_cnt;
  logic             wait_phase;
  logic             rdy_phase;

  xbus_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  xbus_wait_cfg #(.N_RANGES(N_RANGES), .FIELD_W(FIELD_W)) u_cfg (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .we          (cfg_we),
    .wdata       (cfg_wdata),
    .cfg         (cfg),
    .fields_zero (fields_zero)
  );

  xbus_wait_calc #(.N_RANGES(N_RANGES), .FIELD_W(FIELD_W)) u_calc (
    .cfg      (cfg),
    .sel      (req_range),
    .wait_cnt (wait_cnt)
  );

  xbus_wait_seq #(.CNT_W(CNT_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req        (req),
    .wait_cnt   (wait_cnt),
    .ext_ready  (ext_ready),
    .stall      (stall),
    .done       (done),
    .wait_phase (wait_phase),
    .rdy_phase  (rdy_phase)
  );

  assign count_clk_en = ~fields_zero | wait_phase;

endmodule

// File: rtl/xbus_wait_checker.sv
module xbus_wait_checker (
  input logic clk,
  input logic rst_n,
  input logic req,
  input logic ext_ready,
  input logic stall,
  input logic done,
  input logic count_clk_en,
  input logic wait_phase,
  input logic rdy_phase
);

  a_r3_accept_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !stall && !done) |=> stall);

  a_r3_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(stall && done));

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !stall);

  a_r5_ready_low_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_phase && !ext_ready) |=> (rdy_phase && stall));

  a_r5_ready_high_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (rdy_phase && ext_ready) |=> done);

  a_r5_wait_ignores_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wait_phase |=> (wait_phase || rdy_phase));

  a_r8_zero_skips_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_clk_en && req && !stall && !done) |=> rdy_phase);

endmodule

bind xbus_wait_gen xbus_wait_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .req          (req),
  .ext_ready    (ext_ready),
  .stall        (stall),
  .done         (done),
  .count_clk_en (count_clk_en),
  .wait_phase   (wait_phase),
  .rdy_phase    (rdy_phase)
);

// File: tb/xbus_wait_gen_test.sv
module xbus_wait_gen_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [15:0] cfg_wdata;
  logic        req;
  logic [2:0]  req_range;
  logic        ext_ready;
  logic        stall;
  logic        done;
  logic        count_clk_en;

  int checks;
  int fails;

  xbus_wait_gen uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .req          (req),
    .req_range    (req_range),
    .ext_ready    (ext_ready),
    .stall        (stall),
    .done         (done),
    .count_clk_en (count_clk_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] mk_cfg(input int f0, input int f1, input int f2,
                                         input int f3, input int f4, input bit dbl);
    logic [15:0] v;
    v = '0;
    v[2:0]   = 3'(f0);
    v[5:3]   = 3'(f1);
    v[8:6]   = 3'(f2);
    v[11:9]  = 3'(f3);
    v[14:12] = 3'(f4);
    v[15]    = dbl;
    return v;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [15:0] v);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_wdata = v;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  // wr_mode 0: none, 1: write in the acceptance cycle, 2: write in cycle 2 of the access
  task automatic access(input int rng, input int m, input int exp_w, input string tag,
                        input int wr_mode, input logic [15:0] wr_val);
    int stall_n;
    int done_at;
    int span;
    stall_n = 0;
    done_at = -1;
    span    = (exp_w > m) ? exp_w : m;
    @(negedge clk);
    req       = 1'b1;
    req_range = 3'(rng);
    if (wr_mode == 1) begin
      cfg_we    = 1'b1;
      cfg_wdata = wr_val;
    end
    @(negedge clk);
    req    = 1'b0;
    cfg_we = 1'b0;
    for (int i = 1; i < 60; i++) begin
      ext_ready = (i > m);
      if (wr_mode == 2 && i == 2) begin
        cfg_we    = 1'b1;
        cfg_wdata = wr_val;
      end else begin
        cfg_we = 1'b0;
      end
      if (done) begin
        done_at = i;
        break;
      end
      if (stall) stall_n++;
      @(negedge clk);
    end
    cfg_we = 1'b0;
    check({tag, " stall length"}, stall_n, span + 1);
    check({tag, " done cycle"}, done_at, span + 2);
    @(negedge clk);
    check({tag, " done one cycle (R3)"}, int'(done) + int'(stall), 0);
    ext_ready = 1'b1;
  endtask

  task automatic t_reset;
    check("R1 stall after reset", int'(stall), 0);
    check("R1 done after reset", int'(done), 0);
    check("R1 count_clk_en after reset", int'(count_clk_en), 1);
    access(3, 0, 7, "R1 default range3", 0, '0);
    access(0, 0, 7, "R1 default range0", 0, '0);
  endtask

  task automatic t_ranges;
    write_cfg(mk_cfg(0, 1, 3, 5, 6, 1'b0));
    check("R2 count_clk_en nonzero cfg", int'(count_clk_en), 1);
    access(0, 0, 0, "R8 R2 range0 zero wait", 0, '0);
    access(1, 0, 1, "R9 R2 range1", 0, '0);
    access(2, 0, 3, "R9 R2 range2", 0, '0);
    access(3, 0, 5, "R9 R3 range3", 0, '0);
    access(4, 0, 6, "R9 R2 range4", 0, '0);
  endtask

  task automatic t_double;
    write_cfg(mk_cfg(0, 1, 3, 5, 6, 1'b1));
    access(4, 0, 12, "R4 range4 doubled", 0, '0);
    access(2, 0, 6, "R4 range2 doubled", 0, '0);
    write_cfg(mk_cfg(0, 1, 3, 5, 7, 1'b1));
    access(4, 0, 14, "R4 max fourteen", 0, '0);
  endtask

  task automatic t_ready;
    access(1, 1, 2, "R5 ready low inside wait ignored", 0, '0);
    access(1, 6, 2, "R5 ready low extends", 0, '0);
    access(0, 4, 0, "R5 zero wait ready low", 0, '0);
  endtask

  task automatic t_hold_req;
    int seen;
    seen = 0;
    @(negedge clk);
    req       = 1'b1;
    req_range = 3'd1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (done) begin
        seen = 1;
        break;
      end
    end
    check("R6 first done seen", seen, 1);
    @(negedge clk);
    check("R6 request in done cycle ignored", int'(stall), 0);
    @(negedge clk);
    check("R6 accepted one cycle later", int'(stall), 1);
    req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (done) break;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic t_overlap;
    write_cfg(mk_cfg(0, 1, 3, 5, 2, 1'b0));
    access(4, 0, 2, "R7 write with acceptance keeps old", 1, mk_cfg(0, 1, 3, 5, 6, 1'b0));
    access(4, 0, 6, "R7 new value on next access", 0, '0);
    access(3, 0, 5, "R7 write mid access keeps old", 2, mk_cfg(0, 1, 3, 1, 6, 1'b0));
    access(3, 0, 1, "R7 mid write applies next", 0, '0);
  endtask

  task automatic t_gate;
    write_cfg(mk_cfg(0, 0, 0, 0, 0, 1'b1));
    check("R8 count_clk_en off all zero", int'(count_clk_en), 0);
    access(2, 0, 0, "R8 zero config access", 0, '0);
    check("R8 count_clk_en stays off", int'(count_clk_en), 0);
    write_cfg(mk_cfg(0, 0, 4, 0, 0, 1'b0));
    check("R8 count_clk_en back on", int'(count_clk_en), 1);
    access(2, 0, 4, "R8 R9 range2 after gate", 0, '0);
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    checks    = 0;
    fails     = 0;
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_wdata = '0;
    req       = 1'b0;
    req_range = '0;
    ext_ready = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ranges();
    t_double();
    t_ready();
    t_hold_req();
    t_overlap();
    t_gate();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule